// File: doc/BRIEF.md
# Bus Address-Error Response and Reporting

This block sits beside a bus target and decides what the target does when an uncorrectable error is detected in the address or attribute phase of a transaction, and how the event is recorded. In conventional bus mode, with parity-error response enabled, the target refuses the transaction by holding off device-select, so the initiator ends it with a master abort. In extended mode the target still completes the bus transaction normally, but the request or completion is dropped before it reaches the internal bus. When the parity-error response is off, both modes let the transaction go on.

Each error also raises a system-error pulse when enabled, and it sets sticky status bits and interrupt status bits that software clears by writing one. A flag on the detect strobe tells an address/attribute error apart from a data-phase error. A data-phase error only sets the parity-error bits, so software can tell which kind of error occurred. In the second extended sub-mode, a strobe tells the ECC log registers to capture the failing transaction.

Top module: `addr_err_resp`

## Requirements
- R1: In conventional mode (`mode_ext`=0), an address/attribute error (`err_det`=1, `err_is_addr`=1) with `cfg_per`=1 drives `no_devsel` high in the same cycle. `no_devsel` is never high in extended mode or without an address/attribute error.
- R2: In extended mode (`mode_ext`=1), an address/attribute error with `cfg_per`=1 drives `drop_fwd` high in the same cycle and leaves `no_devsel` low.
- R3: With `cfg_per`=0, neither `no_devsel` nor `drop_fwd` is raised, in either mode.
- R4: `serr_pulse` is high in the cycle of an address/attribute error only when `cfg_serr_en`=1 and `cfg_per`=1. It is low in every other cycle.
- R5: A cycle with `serr_pulse` high sets status bit `stat[2]` (system error raised) at the next clock edge.
- R6: A cycle with `serr_pulse` high sets interrupt status bit `int_stat[1]` at the next edge only when `msk_serr`=0.
- R7: A cycle with `serr_pulse` high sets interrupt status bit `int_stat[2]` at the next edge only when `en_serr_det`=1.
- R8: Every address/attribute error sets `stat[0]` (address/attribute error) and `stat[1]` (parity error) at the next edge. It also sets `int_stat[0]` when `msk_par`=0.
- R9: A data-phase error (`err_is_addr`=0) sets `stat[1]`, and sets `int_stat[0]` when `msk_par`=0. It leaves `stat[0]` unchanged and raises no `no_devsel`, `drop_fwd` or `serr_pulse`.
- R10: `ecc_capture` is high in the same cycle as an address/attribute error when `mode_ext`=1 and `ext_sub2`=1, whatever `cfg_per` is. It is low otherwise.
- R11: A write with `stat_clr_we`=1 clears each `stat` bit whose `stat_clr` bit is 1. The same holds for `int_clr_we` and `int_clr` on `int_stat`. A bit that is set and cleared in the same cycle ends up set.
- R12: `irq` is the OR of `int_stat[0]` & ~`msk_par`, `int_stat[1]` & ~`msk_serr`, and `int_stat[2]` & `en_serr_det`. It is combinational on the current mask and enable values.
- R13: While `rst_n` is low, all `stat` and `int_stat` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_det | input | 1 | One-cycle strobe: uncorrectable error detected |
| err_is_addr | input | 1 | 1 = address/attribute phase, 0 = data phase |
| mode_ext | input | 1 | 0 = conventional bus mode, 1 = extended mode |
| ext_sub2 | input | 1 | Second extended sub-mode (ECC logging) |
| cfg_per | input | 1 | Parity-error response enable |
| cfg_serr_en | input | 1 | System-error enable |
| msk_serr | input | 1 | Mask for system-error-raised interrupt |
| msk_par | input | 1 | Mask for parity-error interrupt |
| en_serr_det | input | 1 | Enable for system-error-detected interrupt |
| stat_clr_we | input | 1 | Write-one-to-clear strobe for status |
| stat_clr | input | 3 | Bits to clear in `stat` |
| int_clr_we | input | 1 | Write-one-to-clear strobe for interrupt status |
| int_clr | input | 3 | Bits to clear in `int_stat` |
| no_devsel | output | 1 | Suppress device-select (refuse transaction) |
| drop_fwd | output | 1 | Drop the request/completion internally |
| serr_pulse | output | 1 | System-error pulse |
| ecc_capture | output | 1 | Capture strobe for ECC log registers |
| stat | output | 3 | Sticky status: [0] addr/attr error, [1] parity error, [2] system error raised |
| int_stat | output | 3 | Sticky interrupt status: [0] parity, [1] system error raised, [2] system error detected |
| irq | output | 1 | Interrupt request |

## Verification
The response outputs are combinational on the strobe, so a wrong mode or gating decision shows up in the same cycle as `err_det`. A missed, extra or wrongly masked sticky bit shows up on `stat` or `int_stat` one edge later. It stays there until a write-one clear, so the post-clear readback also shows when a bit failed to clear or was cleared while it was being set. A mistake in the interrupt gating shows on `irq` as soon as a mask or enable input changes, with no clock edge needed.

// File: rtl/addr_err_pkg.sv
package addr_err_pkg;
  localparam int STAT_W = 3;
  localparam int INT_W  = 3;
  // status bit positions
  localparam int ST_ADDR = 0;
  localparam int ST_PAR  = 1;
  localparam int ST_SERR = 2;
  // interrupt status bit positions
  localparam int IS_PAR  = 0;
  localparam int IS_SERR = 1;
  localparam int IS_DET  = 2;

  typedef struct packed {
    logic no_devsel;
    logic drop_fwd;
    logic serr;
    logic ecc_cap;
  } resp_t;

  function automatic resp_t decide_resp(input logic addr_err, input logic ext,
                                        input logic sub2, input logic per,
                                        input logic serr_en);
    resp_t r;
    r.no_devsel = addr_err & ~ext & per;
    r.drop_fwd  = addr_err & ext & per;
    r.serr      = addr_err & per & serr_en;
    r.ecc_cap   = addr_err & ext & sub2;
    return r;
  endfunction
endpackage

// File: rtl/addr_err_decide.sv
module addr_err_decide
  import addr_err_pkg::*;
(
  input  logic  err_det,
  input  logic  err_is_addr,
  input  logic  mode_ext,
  input  logic  ext_sub2,
  input  logic  cfg_per,
  input  logic  cfg_serr_en,
  output resp_t resp,
  output logic  ev_addr,
  output logic  ev_par
);
  assign ev_addr = err_det & err_is_addr;
  assign ev_par  = err_det;
  assign resp    = decide_resp(ev_addr, mode_ext, ext_sub2, cfg_per, cfg_serr_en);
endmodule

// File: rtl/addr_err_sticky.sv
module addr_err_sticky #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic         clr_we,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_v[i])   q[i] <= 1'b1;       // set beats clear
      else if (clr_we && clr_v[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_err_resp.sv
module addr_err_resp
  import addr_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_det,
  input  logic              err_is_addr,
  input  logic              mode_ext,
  input  logic              ext_sub2,
  input  logic              cfg_per,
  input  logic              cfg_serr_en,
  input  logic              msk_serr,
  input  logic              msk_par,
  input  logic              en_serr_det,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr,
  input  logic              int_clr_we,
  input  logic [INT_W-1:0]  int_clr,
  output logic              no_devsel,
  output logic              drop_fwd,
  output logic              serr_pulse,
  output logic              ecc_capture,
  output logic [STAT_W-1:0] stat,
  output logic [INT_W-1:0]  int_stat,
  output logic              irq
);
  resp_t             resp;
  logic              ev_addr, ev_par;
  logic [STAT_W-1:0] stat_set;
  logic [INT_W-1:0]  int_set;
  logic [INT_W-1:0]  int_gate;

  addr_err_decide u_decide (
    .err_det(err_det), .err_is_addr(err_is_addr), .mode_ext(mode_ext),
    .ext_sub2(ext_sub2), .cfg_per(cfg_per), .cfg_serr_en(cfg_serr_en),
    .resp(resp), .ev_addr(ev_addr), .ev_par(ev_par)
  );

  assign no_devsel   = resp.no_devsel;
  assign drop_fwd    = resp.drop_fwd;
  assign serr_pulse  = resp.serr;
  assign ecc_capture = resp.ecc_cap;

  // per-bit interrupt gate: masks block, enable admits
  always_comb begin
    int_gate          = '0;
    int_gate[IS_PAR]  = ~msk_par;
    int_gate[IS_SERR] = ~msk_serr;
    int_gate[IS_DET]  = en_serr_det;
  end

  always_comb begin
    stat_set          = '0;
    stat_set[ST_ADDR] = ev_addr;
    stat_set[ST_PAR]  = ev_par;
    stat_set[ST_SERR] = resp.serr;
    int_set           = '0;
    int_set[IS_PAR]   = ev_par;
    int_set[IS_SERR]  = resp.serr;
    int_set[IS_DET]   = resp.serr;
    int_set           = int_set & int_gate;
  end

  addr_err_sticky #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_v(stat_set),
    .clr_we(stat_clr_we), .clr_v(stat_clr), .q(stat)
  );

  addr_err_sticky #(.W(INT_W)) u_int (
    .clk(clk), .rst_n(rst_n), .set_v(int_set),
    .clr_we(int_clr_we), .clr_v(int_clr), .q(int_stat)
  );

  assign irq = |(int_stat & int_gate);
endmodule

// File: rtl/addr_err_resp_chk.sv
module addr_err_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_det,
  input logic       err_is_addr,
  input logic       mode_ext,
  input logic       ext_sub2,
  input logic       cfg_per,
  input logic       cfg_serr_en,
  input logic       msk_serr,
  input logic       msk_par,
  input logic       stat_clr_we,
  input logic       no_devsel,
  input logic       drop_fwd,
  input logic       serr_pulse,
  input logic       ecc_capture,
  input logic [2:0] stat,
  input logic [2:0] int_stat,
  input logic       irq
);
  assert_refuse_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det && err_is_addr && !mode_ext && cfg_per) |-> no_devsel);
  assert_refuse_only_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    no_devsel |-> (!mode_ext && err_det && err_is_addr));
  assert_drop_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fwd |-> (mode_ext && !no_devsel));
  assert_per_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_per |-> (!no_devsel && !drop_fwd));
  assert_serr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> (cfg_serr_en && cfg_per && err_det && err_is_addr));
  assert_serr_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |=> stat[2]);
  assert_serr_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_pulse && !msk_serr) |=> int_stat[1]);
  assert_addr_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det && err_is_addr) |=> (stat[0] && stat[1]));
  assert_data_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det && !err_is_addr && !stat[0] && !stat_clr_we) |=> !stat[0]);
  assert_ecc_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_capture |-> (err_det && err_is_addr && mode_ext && ext_sub2));
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_stat != 3'b000));
endmodule

bind addr_err_resp addr_err_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_det(err_det), .err_is_addr(err_is_addr),
  .mode_ext(mode_ext), .ext_sub2(ext_sub2), .cfg_per(cfg_per),
  .cfg_serr_en(cfg_serr_en), .msk_serr(msk_serr), .msk_par(msk_par),
  .stat_clr_we(stat_clr_we), .no_devsel(no_devsel), .drop_fwd(drop_fwd),
  .serr_pulse(serr_pulse), .ecc_capture(ecc_capture), .stat(stat),
  .int_stat(int_stat), .irq(irq)
);

// File: tb/addr_err_resp_tb.sv
module addr_err_resp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_det = 0, err_is_addr = 0, mode_ext = 0, ext_sub2 = 0;
  logic cfg_per = 0, cfg_serr_en = 0, msk_serr = 0, msk_par = 0, en_serr_det = 0;
  logic stat_clr_we = 0, int_clr_we = 0;
  logic [2:0] stat_clr = 0, int_clr = 0;
  logic no_devsel, drop_fwd, serr_pulse, ecc_capture, irq;
  logic [2:0] stat, int_stat;
  int total = 0, bad = 0;

  always #10 clk = ~clk; // 50 MHz

  addr_err_resp u_dut (
    .clk(clk), .rst_n(rst_n), .err_det(err_det), .err_is_addr(err_is_addr),
    .mode_ext(mode_ext), .ext_sub2(ext_sub2), .cfg_per(cfg_per),
    .cfg_serr_en(cfg_serr_en), .msk_serr(msk_serr), .msk_par(msk_par),
    .en_serr_det(en_serr_det), .stat_clr_we(stat_clr_we), .stat_clr(stat_clr),
    .int_clr_we(int_clr_we), .int_clr(int_clr), .no_devsel(no_devsel),
    .drop_fwd(drop_fwd), .serr_pulse(serr_pulse), .ecc_capture(ecc_capture),
    .stat(stat), .int_stat(int_stat), .irq(irq)
  );

  // stimulus {addr,ext,sub2,per,serr_en,msk_serr,msk_par,en_det}
  // expect   {no_devsel,drop,serr,ecc, stat[2:0], int_stat[2:0]}
  localparam int NV = 8;
  localparam logic [7:0] VIN [NV] = '{
    8'b1_0_0_1_1_0_0_1, 8'b1_0_0_0_1_0_0_1, 8'b1_1_0_1_0_0_0_0, 8'b1_1_1_1_1_1_1_0,
    8'b1_1_1_0_0_0_0_0, 8'b0_0_0_1_1_0_0_1, 8'b0_1_1_1_1_0_1_0, 8'b1_0_0_1_1_1_0_1};
  localparam logic [9:0] VEXP [NV] = '{
    10'b1_0_1_0_111_111, 10'b0_0_0_0_011_001, 10'b0_1_0_0_011_001, 10'b0_1_1_1_111_000,
    10'b0_0_0_1_011_001, 10'b0_0_0_0_010_001, 10'b0_0_0_0_010_000, 10'b1_0_1_0_111_101};
  localparam string VTAG [NV] = '{"R1 R4 R5 R6 R7 R8", "R3 R8", "R2 R8", "R2 R4 R10 R6 R7",
    "R3 R10", "R9 R4", "R9 R10", "R6 R7 R1"};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    stat_clr_we = 1; stat_clr = 3'b111; int_clr_we = 1; int_clr = 3'b111;
    @(negedge clk);
    stat_clr_we = 0; stat_clr = 0; int_clr_we = 0; int_clr = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R13 reset stat", stat, 0);
    chk("R13 reset int_stat", int_stat, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {err_is_addr, mode_ext, ext_sub2, cfg_per, cfg_serr_en, msk_serr, msk_par, en_serr_det} = VIN[v];
      err_det = 1;
      #1;
      chk({VTAG[v], " resp"}, {no_devsel, drop_fwd, serr_pulse, ecc_capture}, VEXP[v][9:6]);
      @(negedge clk);
      err_det = 0;
      #1;
      chk({VTAG[v], " serr one cycle"}, serr_pulse, 0);
      chk({VTAG[v], " stat"}, stat, VEXP[v][5:3]);
      chk({VTAG[v], " int_stat"}, int_stat, VEXP[v][2:0]);
      chk({VTAG[v], " R12 irq"}, irq, (VEXP[v][2:0] != 0) ? 1 : 0);
      clear_all();
      #1;
      chk({VTAG[v], " R11 cleared"}, {stat, int_stat}, 0);
    end

    // R12: masking after the fact hides the interrupt but keeps the bit
    {err_is_addr, mode_ext, ext_sub2, cfg_per, cfg_serr_en, msk_serr, msk_par, en_serr_det} = 8'b0;
    err_det = 1;
    @(negedge clk);
    err_det = 0;
    #1;
    chk("R12 irq parity", irq, 1);
    msk_par = 1;
    #1;
    chk("R12 irq masked", irq, 0);
    chk("R12 bit kept", int_stat, 3'b001);
    msk_par = 0;

    // R11: partial clear, then set-wins-over-clear
    stat_clr_we = 1; stat_clr = 3'b001;
    @(negedge clk);
    stat_clr_we = 0; stat_clr = 0;
    #1;
    chk("R11 partial clear", stat, 3'b010);
    stat_clr_we = 1; stat_clr = 3'b010; err_det = 1; // data error again
    @(negedge clk);
    stat_clr_we = 0; stat_clr = 0; err_det = 0;
    #1;
    chk("R11 set wins", stat, 3'b010);
    int_clr_we = 1; int_clr = 3'b001;
    @(negedge clk);
    int_clr_we = 0; int_clr = 0;
    #1;
    chk("R11 int clear", int_stat, 3'b000);

    // R7: detected interrupt only with enable, asserted-int masked
    {err_is_addr, mode_ext, ext_sub2, cfg_per, cfg_serr_en, msk_serr, msk_par, en_serr_det} = 8'b1_0_0_1_1_1_1_1;
    err_det = 1;
    @(negedge clk);
    err_det = 0;
    #1;
    chk("R7 detected int only", int_stat, 3'b100);
    chk("R7 irq", irq, 1);
    en_serr_det = 0;
    #1;
    chk("R12 irq enable off", irq, 0);

    // R13: reset mid-run clears sticky bits
    rst_n = 0;
    #1;
    chk("R13 async reset", {stat, int_stat}, 0);
    @(negedge clk);
    rst_n = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule